// File: doc/BRIEF.md
# Function-Unit Dependency Matrix

This block tracks hazards between eight in-flight function units. Load and store units are counted as ordinary units. Each unit owns one row and one column of a square grid of one-bit cells. Row i holds two bits per other unit j:

- a read-hold bit, which means unit i needs the result of unit j before it may read its operands;
- a write-hold bit, which means unit i must not commit its result before unit j does.

When a new instruction is issued to an idle unit, the issue logic supplies the sets of units it depends on. The matrix stores only those that are still in flight.

For every unit the block raises two grants. The read grant lasts one cycle and lets the unit fetch its operands and start executing. The commit grant lets the unit write back the result it has been buffering. The commit grant is withheld in four cases: a write-hold bit in the unit's row is still set, the unit has not read its operands yet, its result is not ready, or the unit is holding write prevention. Write prevention is used for a possible exception or an unresolved speculation.

A committing unit clears its whole column at once, which releases every unit that waits on it. A squash input frees a unit and clears both its row and its column. An ordering flag on the issue port makes the new instruction wait for every older busy unit before it commits, so results retire in program order.

Top module: `dep_matrix_top`

## Requirements
- R1: After reset no unit is busy, and every read grant, commit grant and the stall output are low.
- R2: Issuing to an idle unit with no live dependencies makes that unit busy after the next clock edge. Its read grant is high in the cycle after issue and is low from the following cycle on.
- R3: A unit issued with a read dependency on a busy unit j gets no read grant until unit j commits. The grant appears in the cycle after unit j's commit grant.
- R4: A unit issued with a write dependency on a busy unit j gets no commit grant until unit j has committed, even when it has read its operands and its result is ready.
- R5: The commit grant of a unit is high in the same cycle when all of these hold: the unit is busy, it has read its operands, its result-ready bit is 1, its write-prevention bit is 0, and no write-hold bit is set in its row. The unit is idle after the following clock edge.
- R6: While a unit's write-prevention bit is 1, its commit grant stays low.
- R7: A squash on a busy unit frees it after the next edge and removes every dependency on it. A unit that was waiting only on the squashed unit then gets its read grant in the next cycle. No grant is given to a unit in a cycle in which it is squashed.
- R8: Issuing to a unit that is busy raises the stall output in the same cycle and leaves the state of that unit unchanged.
- R9: With the ordering flag set, the new unit gets a write dependency on every unit that is busy at issue. It cannot commit until all of those units have left.
- R10: Dependency bits on idle units, on the issued unit itself, and on a unit that commits or is squashed in the issue cycle are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | A new instruction is offered this cycle |
| issueUnit | input | 3 | Index of the unit receiving the instruction |
| issueRdDeps | input | 8 | Units whose results the instruction reads (bit j = unit j) |
| issueWrDeps | input | 8 | Units that must commit before the instruction commits |
| issueInOrder | input | 1 | Add a write dependency on every busy unit |
| resultReady | input | 8 | Per unit: buffered result is available |
| holdWrite | input | 8 | Per unit: write prevention, blocks commit |
| goDie | input | 8 | Per unit: squash |
| issueStall | output | 1 | Offered instruction targets a busy unit and is refused |
| goRead | output | 8 | Per unit: operand read grant |
| goWrite | output | 8 | Per unit: commit grant |
| unitBusy | output | 8 | Per unit: instruction in flight |

## Verification
The grants and the stall output are combinational from the registered matrix and the current inputs, so they are due in the same cycle as the stimulus that enables them. Issue, commit and squash change the stored state at the next rising edge, so their effects are due one cycle later. The bench drives inputs on the falling edge and samples one time unit afterwards. It compares against a cycle model that it steps at every rising edge, so each expected value lines up with the cycle in which the design must produce it. Directed sequences cover the timing points that matter: a read grant released the cycle after its producer commits, commit held by write prevention and by ordering, and dependencies dropped when their producer leaves in the same cycle as the issue.

// File: rtl/dep_matrix_pkg.sv
package dep_matrix_pkg;
  localparam int UNITS = 8;
  localparam int IDXW  = $clog2(UNITS);

  // strobes from control to the cell array
  typedef struct packed {
    logic [UNITS-1:0] rowLoad;   // one-hot: row written at issue
    logic [UNITS-1:0] rdSet;     // read-hold bits for the loaded row
    logic [UNITS-1:0] wrSet;     // write-hold bits for the loaded row
    logic [UNITS-1:0] colClear;  // columns of leaving units
    logic [UNITS-1:0] rowClear;  // rows of squashed units
  } strobeT;
endpackage

// File: rtl/dep_matrix_cells.sv
module dep_matrix_cells
  import dep_matrix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  output logic [UNITS-1:0] rowRdAny,
  output logic [UNITS-1:0] rowWrAny
);
  logic [UNITS-1:0] rdBits [UNITS];
  logic [UNITS-1:0] wrBits [UNITS];
  logic [UNITS-1:0] colAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < UNITS; i++) begin
        rdBits[i] <= '0;
        wrBits[i] <= '0;
      end
    end else begin
      for (int i = 0; i < UNITS; i++) begin
        if (strobe.rowLoad[i]) begin
          rdBits[i] <= strobe.rdSet;
          wrBits[i] <= strobe.wrSet;
        end else if (strobe.rowClear[i]) begin
          rdBits[i] <= '0;
          wrBits[i] <= '0;
        end else begin
          rdBits[i] <= rdBits[i] & ~strobe.colClear;
          wrBits[i] <= wrBits[i] & ~strobe.colClear;
        end
      end
    end
  end

  always_comb begin
    colAny = '0;
    for (int i = 0; i < UNITS; i++) begin
      rowRdAny[i] = |rdBits[i];
      rowWrAny[i] = |wrBits[i];
      colAny      = colAny | rdBits[i] | wrBits[i];
    end
  end

  for (genvar g = 0; g < UNITS; g++) begin : gChk
    // R5 / R7: a leaving unit's column is empty after the edge
    p_col_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.colClear[g] |=> !colAny[g]);
    // R10: no unit ever depends on itself
    p_no_self_dep_r10: assert property (@(posedge clk) disable iff (!rstN)
      !rdBits[g][g] && !wrBits[g][g]);
  end
endmodule

// File: rtl/dep_matrix_ctrl.sv
module dep_matrix_ctrl
  import dep_matrix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [IDXW-1:0]  issueUnit,
  input  logic [UNITS-1:0] issueRdDeps,
  input  logic [UNITS-1:0] issueWrDeps,
  input  logic             issueInOrder,
  input  logic [UNITS-1:0] resultReady,
  input  logic [UNITS-1:0] holdWrite,
  input  logic [UNITS-1:0] goDie,
  input  logic [UNITS-1:0] rowRdAny,
  input  logic [UNITS-1:0] rowWrAny,
  output strobeT           strobe,
  output logic             issueStall,
  output logic [UNITS-1:0] goRead,
  output logic [UNITS-1:0] goWrite,
  output logic [UNITS-1:0] unitBusy
);
  logic [UNITS-1:0] busyQ, readQ;
  logic [UNITS-1:0] issueHot, loadHot, killNow, leaving, liveMask;
  logic             issueOk;

  assign issueHot   = {{(UNITS-1){1'b0}}, 1'b1} << issueUnit;
  assign issueStall = issueValid && busyQ[issueUnit];
  assign issueOk    = issueValid && !busyQ[issueUnit];
  assign loadHot    = issueOk ? issueHot : '0;

  assign goRead   = busyQ & ~readQ & ~rowRdAny & ~goDie;
  assign goWrite  = busyQ & readQ & resultReady & ~holdWrite & ~rowWrAny & ~goDie;
  assign killNow  = goDie & busyQ;
  assign leaving  = goWrite | killNow;
  assign liveMask = busyQ & ~leaving & ~issueHot;

  always_comb begin
    strobe.rowLoad  = loadHot;
    strobe.rdSet    = issueRdDeps & liveMask;
    strobe.wrSet    = (issueWrDeps | (issueInOrder ? busyQ : '0)) & liveMask;
    strobe.colClear = leaving;
    strobe.rowClear = killNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= '0;
      readQ <= '0;
    end else begin
      busyQ <= (busyQ & ~leaving) | loadHot;
      readQ <= (readQ | goRead) & ~leaving & ~loadHot;
    end
  end

  assign unitBusy = busyQ;

  for (genvar g = 0; g < UNITS; g++) begin : gChk
    p_read_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
      goRead[g] |=> !goRead[g]);
    p_commit_frees_r5: assert property (@(posedge clk) disable iff (!rstN)
      goWrite[g] |=> !busyQ[g]);
    p_die_frees_r7: assert property (@(posedge clk) disable iff (!rstN)
      (goDie[g] && busyQ[g]) |=> !busyQ[g]);
  end
  // R8: a refused issue leaves the target busy
  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueStall && !leaving[issueUnit]) |=> busyQ[$past(issueUnit)]);
endmodule

// File: rtl/dep_matrix_top.sv
module dep_matrix_top
  import dep_matrix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [IDXW-1:0]  issueUnit,
  input  logic [UNITS-1:0] issueRdDeps,
  input  logic [UNITS-1:0] issueWrDeps,
  input  logic             issueInOrder,
  input  logic [UNITS-1:0] resultReady,
  input  logic [UNITS-1:0] holdWrite,
  input  logic [UNITS-1:0] goDie,
  output logic             issueStall,
  output logic [UNITS-1:0] goRead,
  output logic [UNITS-1:0] goWrite,
  output logic [UNITS-1:0] unitBusy
);
  strobeT           strobe;
  logic [UNITS-1:0] rowRdAny, rowWrAny;

  dep_matrix_ctrl uCtrl (
    .clk, .rstN, .issueValid, .issueUnit, .issueRdDeps, .issueWrDeps,
    .issueInOrder, .resultReady, .holdWrite, .goDie,
    .rowRdAny, .rowWrAny, .strobe, .issueStall, .goRead, .goWrite, .unitBusy
  );

  dep_matrix_cells uCells (
    .clk, .rstN, .strobe, .rowRdAny, .rowWrAny
  );
endmodule

// File: tb/sim_dep_matrix_top.sv
module sim_dep_matrix_top;
  import dep_matrix_pkg::*;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 20000;

  logic clk = 0, rstN = 0;
  logic issueValid = 0, issueInOrder = 0;
  logic [IDXW-1:0]  issueUnit = '0;
  logic [UNITS-1:0] issueRdDeps = '0, issueWrDeps = '0;
  logic [UNITS-1:0] resultReady = '0, holdWrite = '0, goDie = '0;
  logic             issueStall;
  logic [UNITS-1:0] goRead, goWrite, unitBusy;

  int checks = 0, errors = 0, cycles = 0;

  // bench model of the stored state
  logic [UNITS-1:0] mBusy = '0, mRead = '0;
  logic [UNITS-1:0] mRd [UNITS];
  logic [UNITS-1:0] mWr [UNITS];

  dep_matrix_top u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <= %0d", cycles, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [UNITS-1:0] expRead();
    logic [UNITS-1:0] r;
    for (int i = 0; i < UNITS; i++)
      r[i] = mBusy[i] & ~mRead[i] & ~(|mRd[i]) & ~goDie[i];
    return r;
  endfunction

  function automatic logic [UNITS-1:0] expWrite();
    logic [UNITS-1:0] r;
    for (int i = 0; i < UNITS; i++)
      r[i] = mBusy[i] & mRead[i] & resultReady[i] & ~holdWrite[i] & ~(|mWr[i]) & ~goDie[i];
    return r;
  endfunction

  task automatic settle();
    #1;
    chk("R2 busy", unitBusy, mBusy);
    chk("R3 goRead", goRead, expRead());
    chk("R5 goWrite", goWrite, expWrite());
    chk("R8 stall", issueStall, issueValid & mBusy[issueUnit]);
  endtask

  task automatic advance();
    logic [UNITS-1:0] gr, gw, gone, live, hot;
    logic ok;
    gr = expRead(); gw = expWrite();
    gone = gw | (goDie & mBusy);
    hot = UNITS'(1) << issueUnit;
    ok = issueValid & ~mBusy[issueUnit];
    live = mBusy & ~gone & ~hot;
    @(posedge clk);
    for (int i = 0; i < UNITS; i++) begin
      if (ok && i == int'(issueUnit)) begin
        mRd[i] = issueRdDeps & live;
        mWr[i] = (issueWrDeps | (issueInOrder ? mBusy : '0)) & live;
      end else if (goDie[i] & mBusy[i]) begin
        mRd[i] = '0; mWr[i] = '0;
      end else begin
        mRd[i] &= ~gone; mWr[i] &= ~gone;
      end
    end
    mRead = (mRead | gr) & ~gone & ~(ok ? hot : '0);
    mBusy = (mBusy & ~gone) | (ok ? hot : '0);
    @(negedge clk);
  endtask

  task automatic issue(int u, logic [UNITS-1:0] rd, logic [UNITS-1:0] wr, logic ord);
    issueValid = 1; issueUnit = IDXW'(u);
    issueRdDeps = rd; issueWrDeps = wr; issueInOrder = ord;
  endtask

  task automatic idle();
    issueValid = 0; issueRdDeps = '0; issueWrDeps = '0; issueInOrder = 0;
  endtask

  initial begin
    for (int i = 0; i < UNITS; i++) begin mRd[i] = '0; mWr[i] = '0; end
    void'($urandom(1234));
    repeat (2) @(negedge clk);
    rstN = 1;
    settle();
    chk("R1 busy", unitBusy, 0);
    chk("R1 grants", {goRead, goWrite, 7'd0, issueStall}, 0);

    issue(2, 0, 0, 0); settle(); advance(); idle();
    settle(); chk("R2 read grant", goRead[2], 1);
    advance(); settle(); chk("R2 read once", goRead[2], 0);

    issue(5, 8'h04, 0, 0); settle(); advance();
    issue(6, 0, 8'h04, 0); settle(); chk("R3 held", goRead[5], 0);
    advance(); idle(); settle(); advance();
    resultReady[6] = 1; settle(); chk("R4 write held", goWrite[6], 0);
    resultReady[2] = 1; holdWrite[2] = 1; settle(); chk("R6 prevented", goWrite[2], 0);
    holdWrite[2] = 0; settle(); chk("R5 commit", goWrite[2], 1);
    advance(); resultReady[2] = 0; settle();
    chk("R5 freed", unitBusy[2], 0);
    chk("R3 released", goRead[5], 1);
    chk("R4 released", goWrite[6], 1);
    advance(); resultReady = '0; settle();

    issue(1, 8'h0A, 0, 0); settle(); advance(); idle();
    settle(); chk("R10 idle and self dropped", goRead[1], 1);
    advance();
    issue(3, 8'h02, 0, 0); settle(); advance(); idle();
    settle(); chk("R7 waiting", goRead[3], 0);
    goDie[1] = 1; settle(); advance(); goDie = '0; settle();
    chk("R7 freed", unitBusy[1], 0);
    chk("R7 released", goRead[3], 1);
    advance();

    issue(4, 0, 0, 1); settle(); advance(); idle(); settle(); advance();
    resultReady[4] = 1; settle(); chk("R9 ordered", goWrite[4], 0);
    issue(4, 8'hFF, 8'hFF, 0); settle(); chk("R8 refused", issueStall, 1);
    advance(); idle(); settle(); chk("R8 unchanged", goWrite[4], 0);
    issue(7, 8'h08, 0, 0); goDie[3] = 1; settle(); advance(); idle(); goDie = '0;
    settle(); chk("R10 leaving dropped", goRead[7], 1);
    resultReady = '0;
    goDie = '1; settle(); advance(); goDie = '0; settle();

    for (int c = 0; c < 4000; c++) begin
      issueValid   = ($urandom % 2) == 0;
      issueUnit    = IDXW'($urandom);
      issueRdDeps  = UNITS'($urandom) & UNITS'($urandom);
      issueWrDeps  = UNITS'($urandom) & UNITS'($urandom);
      issueInOrder = ($urandom % 4) == 0;
      resultReady  = UNITS'($urandom);
      holdWrite    = UNITS'($urandom) & UNITS'($urandom);
      goDie        = (($urandom % 12) == 0) ? UNITS'(1) << ($urandom % UNITS) : '0;
      settle();
      advance();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule